// File: doc/BRIEF.md
# Compact JTAG Link Mode Monitor

This block watches a two-wire compact JTAG link, a test clock and one shared mode/data line, and works out which link mode is in force. Both pins are brought into a faster system clock domain. Each time the data line toggles while the test clock is high, an escape counter goes up by one. On the next rising test-clock edge the block judges that count. It may drop back to plain four-wire operation, or it may open an online activation sequence.

During activation the block counts packet bits on rising test-clock edges and reports which packet field the current bit belongs to. A packet is 12 bits long, or 36 bits if it is extended. When the packet is over, the block reports the three-phase serial scan format as active. It also tracks the phase of that format and sends a one-cycle request that puts the downstream TAP controller into Test-Logic-Reset.

The block has no software access and does not take part in the scan data path. A debug front end uses its outputs to steer the TAP it serves.

Top module: `cjtag_link_monitor`

State codes on `mode_code_o`:

| Code | State | Meaning |
|------|-------|---------|
| 0 | LM_FOUR_WIRE | Plain four-wire operation |
| 1 | LM_OPTION | Activation packet, option bits |
| 2 | LM_EXT_CMD | Activation packet, extended-command bits |
| 3 | LM_CHECK | Activation packet, check bits |
| 4 | LM_SPARE | Extended packet, spare bits |
| 5 | LM_TP_DELAY | Extended packet, TP delay bits |
| 6 | LM_TP_REV | Extended packet, TP revision bits |
| 7 | LM_TP_STATE | Extended packet, TP state bits |
| 8 | LM_RDY_CNT | Extended packet, ready-count bits |
| 9 | LM_DLY_CNT | Extended packet, delay-count bits |
| 10 | LM_SCAN_FMT | Extended packet, scan-format bits |
| 11 | LM_OSCAN1 | Three-phase scan format active |

Transitions, all taken on a rising test-clock edge:
- `escape_reset`: from any state to LM_FOUR_WIRE.
- `escape_activate`: from any state to LM_OPTION at bit 1.
- `bit_step`: from one field state to the next.
- `packet_done`: from a field state to LM_OSCAN1.
- `phase_step`: from LM_OSCAN1 to LM_OSCAN1 with the phase advanced.

## Requirements
- R1: After reset, `mode_code_o` is 0 (four-wire), `oscan1_active_o` is 0, `scan_phase_o` is 0 and `tap_reset_o` is 0.
- R2: Data-line toggles that happen while the test clock is low do not add to the escape count and change no output.
- R3: Eight or more data-line toggles inside one test-clock-high window set the mode to code 0 at the next rising test-clock edge. This holds whatever the previous mode was, and the scan phase becomes 0.
- R4: Exactly six toggles inside one high window start activation at the next rising edge, from any mode and even in the middle of a packet. That edge counts as packet bit 1, so the mode becomes code 1.
- R5: A toggle count of 1 to 5, or of 7, has no escape effect. The mode continues as if no toggles had happened: four-wire stays four-wire, a packet keeps counting and the scan phase keeps advancing.
- R6: In a 12-bit packet, bits 1 to 4 report code 1, bits 5 to 8 report code 2 and bits 9 to 12 report code 3.
- R7: If the data line is 0 at packet bit 8, the packet grows to 36 bits. Bits 9–13 then report code 4, 14–16 code 5, 17–18 code 6, 19–23 code 7, 24–25 code 8, 26–27 code 9, 28–32 code 10 and 33–36 code 3.
- R8: On the rising edge after the last packet bit, the mode becomes code 11, `oscan1_active_o` rises, `scan_phase_o` becomes 1 and `tap_reset_o` is high for exactly one system clock cycle.
- R9: While the mode is code 11, each rising test-clock edge that is not an escape moves `scan_phase_o` through 1, 2, 0, 1 and so on. Outside code 11, `scan_phase_o` is 0.
- R10: A rising test-clock edge shows up on the outputs at the third rising system-clock edge after the pin is first sampled high. Between such updates the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the test clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tck_i | input | 1 | Test clock pin, asynchronous to clk |
| tms_i | input | 1 | Shared mode/data pin, asynchronous to clk |
| mode_code_o | output | 4 | Current link mode or packet field code |
| oscan1_active_o | output | 1 | High while the three-phase scan format is active |
| scan_phase_o | output | 2 | Phase of the three-phase scan cycle (0, 1 or 2) |
| tap_reset_o | output | 1 | One-cycle request to force the TAP into Test-Logic-Reset |

## Verification
Each test-clock edge passes through a two-stage synchroniser and one edge register, so the outputs change on the third system-clock edge after the pin goes high. The bench checks that the old value is still present at the second falling system-clock edge after the drive, and that the new value is present at the third. The one-cycle TAP reset request is sampled at that same third falling edge.

A behavioural model changes its state the moment the bench raises the test clock. Every other falling system-clock edge compares the model with the outputs, except within the four cycles that follow a test-clock rise. Escape toggles are spaced two system cycles apart and placed after the synchronised clock has settled high, so that each one is counted exactly once.

// File: rtl/cjtag_mon_pkg.sv
package cjtag_mon_pkg;

    typedef enum logic [3:0] {
        LM_FOUR_WIRE = 4'd0,
        LM_OPTION    = 4'd1,
        LM_EXT_CMD   = 4'd2,
        LM_CHECK     = 4'd3,
        LM_SPARE     = 4'd4,
        LM_TP_DELAY  = 4'd5,
        LM_TP_REV    = 4'd6,
        LM_TP_STATE  = 4'd7,
        LM_RDY_CNT   = 4'd8,
        LM_DLY_CNT   = 4'd9,
        LM_SCAN_FMT  = 4'd10,
        LM_OSCAN1    = 4'd11
    } link_mode_e;

    // Last bit position of each activation packet field
    localparam int F_OPT_END   = 4;
    localparam int F_EXT_END   = 8;
    localparam int F_SPARE_END = 13;
    localparam int F_TPDLY_END = 16;
    localparam int F_TPREV_END = 18;
    localparam int F_TPST_END  = 23;
    localparam int F_RDY_END   = 25;
    localparam int F_DLY_END   = 27;
    localparam int F_FMT_END   = 32;

endpackage

// File: rtl/cjtag_pin_sync.sv
module cjtag_pin_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] tgl_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_pin
        logic [STAGES:0] shreg;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shreg <= '0;
            end else begin
                shreg <= {shreg[STAGES-1:0], pin_i[b]};
            end
        end

        assign lvl_o[b]  = shreg[STAGES-1];
        assign rise_o[b] = shreg[STAGES-1] & ~shreg[STAGES];
        assign tgl_o[b]  = shreg[STAGES-1] ^ shreg[STAGES];
    end

endmodule

// File: rtl/cjtag_escape_counter.sv
module cjtag_escape_counter #(
    parameter int SAT_AT = 8,
    parameter int CNT_W  = $clog2(SAT_AT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tck_hi,
    input  logic             tck_rise,
    input  logic             tms_tgl,
    output logic [CNT_W-1:0] esc_cnt
);

    localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT_AT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            esc_cnt <= '0;
        end else if (tck_rise) begin
            esc_cnt <= '0;
        end else if (tck_hi && tms_tgl && (esc_cnt != SAT_V)) begin
            esc_cnt <= esc_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/cjtag_oac_fsm.sv
module cjtag_oac_fsm
    import cjtag_mon_pkg::*;
#(
    parameter int ESC_ACT   = 6,
    parameter int ESC_RESET = 8,
    parameter int SHORT_LEN = 12,
    parameter int LONG_LEN  = 36,
    parameter int EXT_BIT   = 8,
    parameter int CNT_W     = $clog2(ESC_RESET + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tck_rise,
    input  logic             tms_lvl,
    input  logic [CNT_W-1:0] esc_cnt,
    output logic [3:0]       mode_o,
    output logic             oscan1_o,
    output logic [1:0]       phase_o,
    output logic             tap_reset_o
);

    localparam int POS_W = $clog2(LONG_LEN + 2);
    localparam logic [CNT_W-1:0] ESC_ACT_V   = CNT_W'(ESC_ACT);
    localparam logic [CNT_W-1:0] ESC_RESET_V = CNT_W'(ESC_RESET);
    localparam logic [POS_W-1:0] EXT_BIT_V   = POS_W'(EXT_BIT);
    localparam logic [POS_W-1:0] SHORT_V     = POS_W'(SHORT_LEN);
    localparam logic [POS_W-1:0] LONG_V      = POS_W'(LONG_LEN);

    link_mode_e       mode_q, mode_d, base_mode;
    logic [POS_W-1:0] pos_q, pos_d;
    logic             long_q, long_d;
    logic [1:0]       phase_q, phase_d;
    logic             tap_q, tap_d;

    function automatic link_mode_e field_of(input logic [POS_W-1:0] p, input logic lng);
        int pi;
        pi = int'(p);
        if (pi <= F_OPT_END)                   return LM_OPTION;
        if (pi <= F_EXT_END)                   return LM_EXT_CMD;
        if (!lng)                              return LM_CHECK;
        if (pi <= F_SPARE_END)                 return LM_SPARE;
        if (pi <= F_TPDLY_END)                 return LM_TP_DELAY;
        if (pi <= F_TPREV_END)                 return LM_TP_REV;
        if (pi <= F_TPST_END)                  return LM_TP_STATE;
        if (pi <= F_RDY_END)                   return LM_RDY_CNT;
        if (pi <= F_DLY_END)                   return LM_DLY_CNT;
        if (pi <= F_FMT_END)                   return LM_SCAN_FMT;
        return LM_CHECK;
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= LM_FOUR_WIRE;
            pos_q   <= '0;
            long_q  <= 1'b0;
            phase_q <= 2'd0;
            tap_q   <= 1'b0;
        end else begin
            mode_q  <= mode_d;
            pos_q   <= pos_d;
            long_q  <= long_d;
            phase_q <= phase_d;
            tap_q   <= tap_d;
        end
    end

    // Next state
    always_comb begin
        mode_d    = mode_q;
        pos_d     = pos_q;
        long_d    = long_q;
        phase_d   = phase_q;
        tap_d     = 1'b0;
        base_mode = mode_q;
        if (tck_rise) begin
            if (esc_cnt >= ESC_RESET_V) begin
                base_mode = LM_FOUR_WIRE;
            end else if (esc_cnt == ESC_ACT_V) begin
                base_mode = LM_OPTION;
                pos_d     = '0;
                long_d    = 1'b0;
            end
            mode_d  = base_mode;
            phase_d = 2'd0;
            unique case (base_mode)
                LM_FOUR_WIRE: begin
                    phase_d = 2'd0;
                end
                LM_OSCAN1: begin
                    phase_d = (phase_q == 2'd2) ? 2'd0 : phase_q + 2'd1;
                end
                default: begin
                    pos_d = pos_d + 1'b1;
                    if ((pos_d == EXT_BIT_V) && !tms_lvl) begin
                        long_d = 1'b1;
                    end
                    if (pos_d > (long_d ? LONG_V : SHORT_V)) begin
                        mode_d  = LM_OSCAN1;
                        phase_d = 2'd1;
                        tap_d   = 1'b1;
                    end else begin
                        mode_d = field_of(pos_d, long_d);
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        mode_o      = mode_q;
        oscan1_o    = (mode_q == LM_OSCAN1);
        phase_o     = phase_q;
        tap_reset_o = tap_q;
    end

endmodule

// File: rtl/cjtag_link_monitor.sv
module cjtag_link_monitor #(
    parameter int ESC_ACT   = 6,
    parameter int ESC_RESET = 8,
    parameter int SHORT_LEN = 12,
    parameter int LONG_LEN  = 36,
    parameter int EXT_BIT   = 8,
    parameter int SYNC_STG  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tck_i,
    input  logic       tms_i,
    output logic [3:0] mode_code_o,
    output logic       oscan1_active_o,
    output logic [1:0] scan_phase_o,
    output logic       tap_reset_o
);

    localparam int CNT_W = $clog2(ESC_RESET + 1);

    logic [1:0]       pin_lvl, pin_rise, pin_tgl;
    logic             tck_rise, tck_hi, tms_lvl, tms_tgl;
    logic [CNT_W-1:0] esc_cnt;

    cjtag_pin_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STG)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({tms_i, tck_i}),
        .lvl_o  (pin_lvl),
        .rise_o (pin_rise),
        .tgl_o  (pin_tgl)
    );

    assign tck_hi   = pin_lvl[0];
    assign tck_rise = pin_rise[0];
    assign tms_lvl  = pin_lvl[1];
    assign tms_tgl  = pin_tgl[1];

    cjtag_escape_counter #(
        .SAT_AT (ESC_RESET),
        .CNT_W  (CNT_W)
    ) u_esc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tck_hi   (tck_hi),
        .tck_rise (tck_rise),
        .tms_tgl  (tms_tgl),
        .esc_cnt  (esc_cnt)
    );

    cjtag_oac_fsm #(
        .ESC_ACT   (ESC_ACT),
        .ESC_RESET (ESC_RESET),
        .SHORT_LEN (SHORT_LEN),
        .LONG_LEN  (LONG_LEN),
        .EXT_BIT   (EXT_BIT),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tck_rise    (tck_rise),
        .tms_lvl     (tms_lvl),
        .esc_cnt     (esc_cnt),
        .mode_o      (mode_code_o),
        .oscan1_o    (oscan1_active_o),
        .phase_o     (scan_phase_o),
        .tap_reset_o (tap_reset_o)
    );

endmodule

// File: rtl/cjtag_link_monitor_chk.sv
module cjtag_link_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tck_rise,
    input logic [3:0] mode_code,
    input logic       oscan1_active,
    input logic [1:0] scan_phase,
    input logic       tap_reset
);

    AST_PHASE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !oscan1_active |-> (scan_phase == 2'd0)); // R9

    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        scan_phase != 2'd3); // R9

    AST_ENTRY_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oscan1_active) |-> (scan_phase == 2'd1)); // R8

    AST_ENTRY_TAP_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oscan1_active) |-> tap_reset); // R8

    AST_TAP_RESET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tap_reset |=> !tap_reset); // R8

    AST_TAP_RESET_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        tap_reset |-> (oscan1_active && mode_code == 4'd11)); // R8

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tck_rise |=> $stable(mode_code)); // R10

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tck_rise |=> $stable(scan_phase)); // R10

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_code <= 4'd11); // R7

endmodule

bind cjtag_link_monitor cjtag_link_monitor_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tck_rise      (tck_rise),
    .mode_code     (mode_code_o),
    .oscan1_active (oscan1_active_o),
    .scan_phase    (scan_phase_o),
    .tap_reset     (tap_reset_o)
);

// File: tb/test_cjtag_link_monitor.sv
`timescale 1ns/1ps
module test_cjtag_link_monitor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tck_in = 1'b0;
    logic       tms_in = 1'b0;
    logic [3:0] mode_code_o;
    logic       oscan1_active_o;
    logic [1:0] scan_phase_o;
    logic       tap_reset_o;

    int checks = 0;
    int errors = 0;
    bit quiet  = 1'b0;
    bit done   = 1'b0;

    // Behavioural reference model
    int mdl_mode  = 0;
    int mdl_pos   = 0;
    bit mdl_long  = 1'b0;
    int mdl_phase = 0;
    int mdl_esc   = 0;

    always #5 clk = ~clk;

    cjtag_link_monitor i_cjtag_link_monitor (
        .clk             (clk),
        .rst_n           (rst_n),
        .tck_i           (tck_in),
        .tms_i           (tms_in),
        .mode_code_o     (mode_code_o),
        .oscan1_active_o (oscan1_active_o),
        .scan_phase_o    (scan_phase_o),
        .tap_reset_o     (tap_reset_o)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic int field_code(input int p, input bit lng);
        if (p <= 4) return 1;
        if (p <= 8) return 2;
        if (!lng)   return 3;
        if (p <= 13) return 4;
        if (p <= 16) return 5;
        if (p <= 18) return 6;
        if (p <= 23) return 7;
        if (p <= 25) return 8;
        if (p <= 27) return 9;
        if (p <= 32) return 10;
        return 3;
    endfunction

    task automatic model_rise(input bit tms_v, output bit entered);
        entered = 1'b0;
        if (mdl_esc >= 8) begin
            mdl_mode = 0;
        end else if (mdl_esc == 6) begin
            mdl_mode = 1;
            mdl_pos  = 0;
            mdl_long = 1'b0;
        end
        mdl_esc = 0;
        if (mdl_mode == 0) begin
            mdl_phase = 0;
        end else if (mdl_mode == 11) begin
            mdl_phase = (mdl_phase + 1) % 3;
        end else begin
            mdl_pos++;
            if (mdl_pos == 8 && tms_v == 1'b0) mdl_long = 1'b1;
            if (mdl_pos > (mdl_long ? 36 : 12)) begin
                mdl_mode  = 11;
                mdl_phase = 1;
                entered   = 1'b1;
            end else begin
                mdl_mode  = field_code(mdl_pos, mdl_long);
                mdl_phase = 0;
            end
        end
    endtask

    task automatic chk_model(input string req);
        check(req, "mode_code", int'(mode_code_o), mdl_mode);
        check(req, "oscan1_active", int'(oscan1_active_o), int'(mdl_mode == 11));
        check(req, "scan_phase", int'(scan_phase_o), mdl_phase);
    endtask

    task automatic chk_lit(input string req, input int m, input int a, input int p);
        check(req, "mode_code", int'(mode_code_o), m);
        check(req, "oscan1_active", int'(oscan1_active_o), a);
        check(req, "scan_phase", int'(scan_phase_o), p);
    endtask

    // One test-clock period; escape toggles follow the rise inside the high window
    task automatic pulse(input bit tms_v, input int toggles);
        int prev;
        bit entered;
        tms_in = tms_v;
        repeat (3) @(negedge clk);
        prev   = mdl_mode;
        quiet  = 1'b0;
        tck_in = 1'b1;
        model_rise(tms_v, entered);
        repeat (2) @(negedge clk);
        check("R10", "mode before third edge", int'(mode_code_o), prev);
        @(negedge clk);
        check("R10", "mode at third edge", int'(mode_code_o), mdl_mode);
        check("R8", "tap_reset pulse", int'(tap_reset_o), int'(entered));
        @(negedge clk);
        quiet = 1'b1;
        for (int i = 0; i < toggles; i++) begin
            tms_in = ~tms_in;
            mdl_esc++;
            repeat (2) @(negedge clk);
        end
        tck_in = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic low_toggles(input int n);
        for (int i = 0; i < n; i++) begin
            tms_in = ~tms_in;
            repeat (2) @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    // Continuous comparison outside the update window
    always @(negedge clk) begin
        if (rst_n && quiet && !done) begin
            chk_model("R10");
            check("R10", "tap_reset idle", int'(tap_reset_o), 0);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk_lit("R1", 0, 0, 0);
        check("R1", "tap_reset", int'(tap_reset_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk_lit("R1", 0, 0, 0);
        quiet = 1'b1;

        pulse(1'b1, 0);
        pulse(1'b0, 5);
        pulse(1'b1, 0);
        chk_lit("R5", 0, 0, 0);

        // Short packet
        pulse(1'b0, 6);
        pulse(1'b1, 0);
        chk_lit("R4", 1, 0, 0);
        for (int b = 2; b <= 12; b++) begin
            pulse(1'b1, 0);
            chk_model("R6");
            if (b == 4)  chk_lit("R6", 1, 0, 0);
            if (b == 5)  chk_lit("R6", 2, 0, 0);
            if (b == 8)  chk_lit("R6", 2, 0, 0);
            if (b == 9)  chk_lit("R6", 3, 0, 0);
            if (b == 12) chk_lit("R6", 3, 0, 0);
        end
        pulse(1'b1, 0);
        chk_lit("R8", 11, 1, 1);
        pulse(1'b1, 0);
        chk_lit("R9", 11, 1, 2);
        pulse(1'b1, 7);
        chk_lit("R9", 11, 1, 0);
        pulse(1'b1, 0);
        chk_lit("R5", 11, 1, 1);
        low_toggles(6);
        pulse(1'b1, 0);
        chk_lit("R2", 11, 1, 2);
        pulse(1'b1, 8);
        pulse(1'b1, 0);
        chk_lit("R3", 0, 0, 0);

        // Extended packet
        pulse(1'b1, 6);
        for (int b = 1; b <= 36; b++) begin
            pulse((b == 8) ? 1'b0 : 1'b1, 0);
            chk_model("R7");
            if (b == 9)  chk_lit("R7", 4, 0, 0);
            if (b == 14) chk_lit("R7", 5, 0, 0);
            if (b == 28) chk_lit("R7", 10, 0, 0);
            if (b == 33) chk_lit("R7", 3, 0, 0);
        end
        pulse(1'b1, 0);
        chk_lit("R8", 11, 1, 1);

        // Restart in mid-packet
        pulse(1'b1, 6);
        pulse(1'b1, 0);
        chk_lit("R4", 1, 0, 0);
        pulse(1'b1, 0);
        pulse(1'b1, 6);
        pulse(1'b1, 0);
        chk_lit("R4", 1, 0, 0);
        for (int b = 2; b <= 5; b++) pulse(1'b1, 0);
        chk_lit("R6", 2, 0, 0);
        pulse(1'b1, 9);
        pulse(1'b1, 0);
        chk_lit("R3", 0, 0, 0);
        pulse(1'b1, 3);
        pulse(1'b1, 0);
        chk_lit("R5", 0, 0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule